// File: doc/BRIEF.md
# Chainable PWM Bank with Selectable Tick Sources

This block is a bank of independent pulse-width modulators. Each channel owns a source selector, an 8-bit period register and an 8-bit pulse-width register. A channel's 8-bit counter steps once per tick of its chosen source and wraps after `period` ticks. The output is high while the count is below the pulse width and low for the rest of the period. All timing is derived from one system clock. Fixed prescalers produce single-cycle tick enables at full rate, 1/16, 1/256 and 1/750 of that clock, which is 24 MHz, 1.5 MHz, 93.75 kHz and about 32 kHz when the clock is 24 MHz. A fifth source divides the 1/256 tick by a programmable ratio from 1 to 255; at its reset ratio of 255 this gives about 367.6 Hz. A sixth source counts rising edges of the neighbouring lower channel's output, so channels can be cascaded into long periods.

Period and width writes go into holding registers. A channel copies them into its working registers only when its counter wraps, so a change never cuts a cycle short. Each I/O pin has a route bit that picks either its channel's PWM output or a plain output data bit. Software reaches all registers through a simple synchronous write port. A write with the top address bit clear targets channel `addr[AW-2:2]`, register `addr[1:0]`: 0 is the source, 1 is the period and 2 is the width. A write with the top bit set targets a global register `addr[1:0]`: 0 is the slow divider ratio, 1 is the pin route mask and 2 is the output data.

Top module: `pwm_bank`

## Requirements
- R1: After reset every pin is low, the route mask and output data are 0, every channel uses source 0, and every channel has working period 1 and width 0, so its output stays low.
- R2: Source codes 0 to 3 tick every 750, 1, 16 and 256 system cycles respectively. A channel's output period is its period value times the tick interval of its source.
- R3: Source code 4 ticks every 256×D cycles, where D is the global divider register (reset 255). A write of 0 to the divider is ignored.
- R4: Source code 5 advances a channel once per rising edge of the next lower channel's output. On channel 0, and for codes 6 and 7, the counter holds and the output is frozen.
- R5: In each period the output is high for the first W ticks and low for the remaining ticks. A width of 0 keeps the output constantly low.
- R6: A write of 0 to a period register is ignored, and the previous period is kept.
- R7: A width write larger than the channel's current period register minus 1 is stored as period minus 1. The working width is always below the working period.
- R8: New period and width values take effect only when the counter wraps. The period in progress completes at its old length.
- R9: A pin whose route bit is 1 carries its channel's PWM output. A pin whose route bit is 0 carries its output data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock from which all ticks are derived |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (5) | Write address: bit AW-1 selects global, then channel index, then register |
| wr_data | input | 8 | Write data |
| pin_out | output | NUM_CH (4) | Pin drive, PWM or data per route bit |

## Verification
The bound checker checks several rules on every cycle: period and divider registers never hold zero, the working width stays below the working period, the counter stays inside the period, and the working registers hold between wraps. It also checks that a zero width forces a low output and that channel 0 with the chained source does not count. Only the bench's scenarios can show the absolute tick rates of each source, the programmable divider ratio, the cascaded period product, the exact duty count and the pin routing. It measures these as distances between rising edges and as high-sample counts at the pins.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W = 8;
  localparam int SRC_W  = 3;
  localparam int NUM_FIXED_SRC = 5;

  typedef enum logic [SRC_W-1:0] {
    SRC_32K   = 3'd0,
    SRC_FULL  = 3'd1,
    SRC_FAST  = 3'd2,
    SRC_MID   = 3'd3,
    SRC_SLOW  = 3'd4,
    SRC_CHAIN = 3'd5
  } src_e;

  localparam logic [1:0] CREG_SRC  = 2'd0;
  localparam logic [1:0] CREG_PER  = 2'd1;
  localparam logic [1:0] CREG_WID  = 2'd2;
  localparam logic [1:0] GREG_DIV  = 2'd0;
  localparam logic [1:0] GREG_ROUT = 2'd1;
  localparam logic [1:0] GREG_DATA = 2'd2;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int RATIO = 16,
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(RATIO - 1));
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen import pwm_pkg::*; #(
  parameter int R32K  = 750,
  parameter int RFAST = 16,
  parameter int RMID  = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        div_q,
  output logic [NUM_FIXED_SRC-1:0] tick_vec
);
  logic t_32k, t_fast, t_mid;
  logic [DATA_W-1:0] slow_q, slow_d;
  logic slow_hit;

  pwm_prescale #(.RATIO(R32K))  u_p32k (.clk(clk), .rst_n(rst_n), .tick(t_32k));
  pwm_prescale #(.RATIO(RFAST)) u_pfst (.clk(clk), .rst_n(rst_n), .tick(t_fast));
  pwm_prescale #(.RATIO(RMID))  u_pmid (.clk(clk), .rst_n(rst_n), .tick(t_mid));

  always_comb begin
    slow_hit = t_mid && (slow_q >= div_q - 8'd1);
    slow_d   = slow_q;
    if (t_mid) slow_d = slow_hit ? '0 : slow_q + 8'd1;
    tick_vec[SRC_32K]  = t_32k;
    tick_vec[SRC_FULL] = 1'b1;
    tick_vec[SRC_FAST] = t_fast;
    tick_vec[SRC_MID]  = t_mid;
    tick_vec[SRC_SLOW] = slow_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slow_q <= '0;
    else        slow_q <= slow_d;
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel import pwm_pkg::*; #(
  parameter bit HAS_PREV = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SRC_W-1:0]         src,
  input  logic [NUM_FIXED_SRC-1:0] tick_vec,
  input  logic                     chain_in,
  input  logic [DATA_W-1:0]        per_in,
  input  logic [DATA_W-1:0]        wid_in,
  output logic                     pwm,
  output logic                     wrap,
  output logic [DATA_W-1:0]        cnt,
  output logic [DATA_W-1:0]        act_per,
  output logic [DATA_W-1:0]        act_wid
);
  logic [DATA_W-1:0] cnt_q, cnt_d, per_q, per_d, wid_q, wid_d;
  logic prev_q, chain_tick, tick, last;
  logic [7:0] tick_all;

  always_comb begin
    chain_tick = HAS_PREV && chain_in && !prev_q;
    tick_all   = {2'b00, chain_tick, tick_vec};
    tick       = tick_all[src];
    last       = (cnt_q == per_q - 8'd1);
    wrap       = tick && last;
    cnt_d      = cnt_q;
    per_d      = per_q;
    wid_d      = wid_q;
    if (tick) cnt_d = last ? '0 : cnt_q + 8'd1;
    if (wrap) begin
      per_d = per_in;
      wid_d = (wid_in < per_in) ? wid_in : per_in - 8'd1;
    end
    pwm     = (cnt_q < wid_q);
    cnt     = cnt_q;
    act_per = per_q;
    act_wid = wid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= 8'd1;
      wid_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      wid_q  <= wid_d;
      prev_q <= chain_in;
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank import pwm_pkg::*; #(
  parameter int NUM_CH = 4,
  parameter int R32K   = 750,
  parameter int RFAST  = 16,
  parameter int RMID   = 256,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int AW    = CH_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] pin_out
);
  logic rst_meta, rst_sync_n;
  logic [NUM_CH-1:0][SRC_W-1:0]  src_q, src_d;
  logic [NUM_CH-1:0][DATA_W-1:0] per_q, per_d, wid_q, wid_d;
  logic [NUM_CH-1:0][DATA_W-1:0] cnt, act_per, act_wid;
  logic [NUM_CH-1:0] psel_q, psel_d, odata_q, odata_d, pwm, wrap;
  logic [DATA_W-1:0] div_q, div_d;
  logic [NUM_FIXED_SRC-1:0] tick_vec;
  logic is_glb;
  logic [CH_W-1:0] ch_idx;
  logic [1:0] rsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  always_comb begin
    is_glb  = wr_addr[AW-1];
    ch_idx  = wr_addr[CH_W+1:2];
    rsel    = wr_addr[1:0];
    src_d   = src_q;
    per_d   = per_q;
    wid_d   = wid_q;
    div_d   = div_q;
    psel_d  = psel_q;
    odata_d = odata_q;
    if (wr_en) begin
      if (is_glb) begin
        case (rsel)
          GREG_DIV:  if (wr_data != '0) div_d = wr_data;
          GREG_ROUT: psel_d  = wr_data[NUM_CH-1:0];
          GREG_DATA: odata_d = wr_data[NUM_CH-1:0];
          default: ;
        endcase
      end else begin
        for (int i = 0; i < NUM_CH; i++) begin
          if (ch_idx == CH_W'(i)) begin
            case (rsel)
              CREG_SRC: src_d[i] = wr_data[SRC_W-1:0];
              CREG_PER: if (wr_data != '0) per_d[i] = wr_data;
              CREG_WID: wid_d[i] = (wr_data < per_q[i]) ? wr_data : per_q[i] - 8'd1;
              default: ;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      src_q   <= '0;
      per_q   <= {NUM_CH{8'd1}};
      wid_q   <= '0;
      div_q   <= 8'd255;
      psel_q  <= '0;
      odata_q <= '0;
    end else begin
      src_q   <= src_d;
      per_q   <= per_d;
      wid_q   <= wid_d;
      div_q   <= div_d;
      psel_q  <= psel_d;
      odata_q <= odata_d;
    end
  end

  pwm_tick_gen #(.R32K(R32K), .RFAST(RFAST), .RMID(RMID)) u_ticks (
    .clk(clk), .rst_n(rst_sync_n), .div_q(div_q), .tick_vec(tick_vec)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic chain_src;
    if (g == 0) begin : g_first
      assign chain_src = 1'b0;
    end else begin : g_rest
      assign chain_src = pwm[g-1];
    end
    pwm_channel #(.HAS_PREV(g > 0)) u_ch (
      .clk(clk), .rst_n(rst_sync_n), .src(src_q[g]), .tick_vec(tick_vec),
      .chain_in(chain_src), .per_in(per_q[g]), .wid_in(wid_q[g]),
      .pwm(pwm[g]), .wrap(wrap[g]), .cnt(cnt[g]),
      .act_per(act_per[g]), .act_wid(act_wid[g])
    );
    assign pin_out[g] = psel_q[g] ? pwm[g] : odata_q[g];
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic [NUM_CH-1:0][7:0] per_q,
  input logic [NUM_CH-1:0][7:0] act_per,
  input logic [NUM_CH-1:0][7:0] act_wid,
  input logic [NUM_CH-1:0][7:0] cnt,
  input logic [NUM_CH-1:0][2:0] src_q,
  input logic [NUM_CH-1:0]      pwm,
  input logic [NUM_CH-1:0]      wrap,
  input logic [7:0]             div_q
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_a
    // R6
    per_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      per_q[i] != 8'd0 && act_per[i] != 8'd0);
    // R7
    wid_below_per_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      act_wid[i] < act_per[i]);
    // R8
    hold_until_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !wrap[i] |=> $stable(act_per[i]) && $stable(act_wid[i]));
    // R5
    cnt_in_period_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      cnt[i] < act_per[i]);
    // R5
    zero_wid_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      act_wid[i] == 8'd0 |-> !pwm[i]);
  end

  // R4
  first_chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    src_q[0] == 3'd5 |=> $stable(cnt[0]));
  // R3
  div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    div_q != 8'd0);
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .per_q(per_q), .act_per(act_per),
  .act_wid(act_wid), .cnt(cnt), .src_q(src_q), .pwm(pwm), .wrap(wrap),
  .div_q(div_q)
);

// File: tb/tb_pwm_bank.sv
module tb_pwm_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n, wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;
  logic [NCH-1:0] pin_out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  pwm_bank #(.NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_out(pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cwr(input int ch, input int r, input int data);
    wr(ch * 4 + r, data);
  endtask

  task automatic gwr(input int off, input int data);
    wr(16 + off, data);
  endtask

  task automatic to_rise(input int ch, output int n);
    bit prev;
    prev = pin_out[ch];
    n = 0;
    for (int k = 0; k < 100000; k++) begin
      @(negedge clk);
      n++;
      if (pin_out[ch] && !prev) return;
      prev = pin_out[ch];
    end
  endtask

  task automatic period_of(input int ch, output int p);
    int d;
    to_rise(ch, d);
    to_rise(ch, d);
    to_rise(ch, p);
  endtask

  task automatic highs_from_rise(input int ch, input int n, output int h);
    int d;
    to_rise(ch, d);
    h = int'(pin_out[ch]);
    for (int k = 1; k < n; k++) begin
      @(negedge clk);
      h += int'(pin_out[ch]);
    end
  endtask

  task automatic t_reset;
    int p;
    check(pin_out == '0, "R1 pins low after reset", pin_out, 0);
    gwr(1, 4'hF);
    repeat (20) @(negedge clk);
    check(pin_out == '0, "R1 default width zero keeps routed pins low", pin_out, 0);
    cwr(0, 1, 4); cwr(0, 2, 2);
    period_of(0, p);
    check(p == 3000, "R1 R2 default 32k source period", p, 3000);
  endtask

  task automatic t_sources;
    int p, h;
    cwr(1, 0, 1); cwr(1, 1, 5); cwr(1, 2, 2);
    period_of(1, p);
    check(p == 5, "R2 full-rate source period", p, 5);
    highs_from_rise(1, 5, h);
    check(h == 2, "R5 high ticks per period", h, 2);
    cwr(2, 0, 2); cwr(2, 1, 3); cwr(2, 2, 1);
    period_of(2, p);
    check(p == 48, "R2 1/16 source period", p, 48);
    cwr(3, 0, 3); cwr(3, 1, 2); cwr(3, 2, 1);
    period_of(3, p);
    check(p == 512, "R2 1/256 source period", p, 512);
  endtask

  task automatic t_slow;
    int p;
    gwr(0, 3);
    cwr(3, 0, 4);
    period_of(3, p);
    check(p == 1536, "R3 divided source ratio 3", p, 1536);
    gwr(0, 0);
    period_of(3, p);
    check(p == 1536, "R3 divider write of zero ignored", p, 1536);
  endtask

  task automatic t_width;
    int h, p;
    cwr(1, 1, 10); cwr(1, 2, 0);
    repeat (30) @(negedge clk);
    h = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      h += int'(pin_out[1]);
    end
    check(h == 0, "R5 zero width constant low", h, 0);
    cwr(1, 2, 200);
    highs_from_rise(1, 10, h);
    highs_from_rise(1, 10, h);
    check(h == 9, "R7 width clamped to period-1", h, 9);
    cwr(1, 1, 0);
    period_of(1, p);
    check(p == 10, "R6 period write of zero ignored", p, 10);
  endtask

  task automatic t_boundary;
    int d, k, p;
    cwr(1, 1, 20); cwr(1, 2, 5);
    period_of(1, p);
    check(p == 20, "R8 new period after wrap", p, 20);
    to_rise(1, d);
    cwr(1, 1, 8);
    to_rise(1, k);
    check(2 + k == 20, "R8 period in progress keeps old length", 2 + k, 20);
    to_rise(1, p);
    check(p == 8, "R8 following period uses new value", p, 8);
  endtask

  task automatic t_chain;
    int p;
    bit ref0, ref1, same;
    cwr(0, 0, 1); cwr(0, 1, 4); cwr(0, 2, 2);
    cwr(1, 0, 5); cwr(1, 1, 3); cwr(1, 2, 1);
    period_of(1, p);
    check(p == 12, "R4 cascaded period is product", p, 12);
    cwr(0, 0, 5);
    repeat (3) @(negedge clk);
    ref0 = pin_out[0]; ref1 = pin_out[1]; same = 1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pin_out[0] != ref0 || pin_out[1] != ref1) same = 0;
    end
    check(same, "R4 channel 0 chained source holds", same, 1);
  endtask

  task automatic t_mux;
    gwr(1, 0); gwr(2, 4'b1010);
    @(negedge clk);
    check(pin_out == 4'b1010, "R9 data drives unrouted pins", pin_out, 4'b1010);
    gwr(2, 4'b0101);
    @(negedge clk);
    check(pin_out == 4'b0101, "R9 data pattern two", pin_out, 4'b0101);
    cwr(2, 1, 6); cwr(2, 2, 0);
    gwr(2, 0); gwr(1, 4'b0100);
    repeat (200) @(negedge clk);
    check(pin_out == 4'b0000, "R9 routed pin follows low pwm", pin_out, 0);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sources();
    t_slow();
    t_width();
    t_boundary();
    t_chain();
    t_mux();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule